// File: doc/BRIEF.md
# Frame-Synchronized Receiver Control Register

This block is the control and status register of a serial audio receiver. Software reaches it through a simple write strobe with write data, and it reads back through a combinational read bus. From the stored fields it drives four signals: the receiver's effective enable, the bit clock enable, a one-cycle pulse that resets the FIFO pointers and a one-cycle soft reset pulse for the receive logic.

Software can turn the receiver or its bit clock off at any time. The block does not act on that request while a frame is in progress. The enable stays on, and reads back as 1, until the datapath signals the end of the frame. If no frame is running, the request takes effect on the next clock edge. A low-power mode (stop, low-leakage stop or debug) gates the effective enable. A sticky flag records word-start events. Software clears the flag by writing 1 to its bit.

Top module: `rx_ctrl_reg`

## Requirements
- R1: When bit 31 (receiver enable) is written 0 while `frame_active` is 1 and `frame_end` is 0, bit 31 and `rx_active` stay 1. Both drop to 0 at the first clock edge where `frame_end` is 1 or `frame_active` is 0. A write of 1 to bit 31 sets the bit at the next edge.
- R2: Writing 1 to bit 31 also sets bit 28 (bit clock enable). While bit 31 reads 1, bit 28 reads 1.
- R3: When bit 28 is written 0 with bit 31 clear, bit 28 and `bclk_on` stay 1 until the same frame boundary as in R1. `bclk_on` always equals bit 28 and does not depend on any low-power mode.
- R4: A write with bit 25 set makes `fifo_rst` high for exactly the one cycle after the write edge. Bit 25 always reads 0.
- R5: A write with bit 24 set makes `soft_rst` and `fifo_rst` high for the one cycle after the write edge, and it clears bit 20. Bits 31, 30, 29 and 28 keep their values. Bit 24 always reads 0.
- R6: When `stop_mode` is 1, `rx_active` is 0 unless bit 30 (stop enable) is 1. When `lls_mode` is 1, `rx_active` is 0 whatever bit 30 holds.
- R7: While `debug_mode` is 1 and bit 29 (debug enable) is 0, `rx_active` goes to 0 after the current frame ends, or at the next edge if no frame is in progress. It comes back once either condition is removed.
- R8: Bit 20 (word-start flag) is set by `word_start`. A write with bit 20 set clears it, and a write with bit 20 at 0 leaves it unchanged. If `word_start` and the clear land in the same cycle, the flag is 1.
- R9: Bits 27..21 other than 25 and 24, and bits 19..0, ignore writes and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Register read value |
| frame_active | input | 1 | A receive frame is in progress |
| frame_end | input | 1 | Last cycle of the current frame |
| word_start | input | 1 | Start of the configured word detected |
| stop_mode | input | 1 | Chip is in stop mode |
| lls_mode | input | 1 | Chip is in a low-leakage stop mode |
| debug_mode | input | 1 | Chip is halted for debug |
| rx_active | output | 1 | Effective receiver enable |
| bclk_on | output | 1 | Receive bit clock enable |
| fifo_rst | output | 1 | One-cycle FIFO pointer reset |
| soft_rst | output | 1 | One-cycle receiver logic reset |

## Verification
A write or a `word_start` sampled at one rising edge shows up in `rdata` and in the one-cycle pulses right after that edge. A deferred enable drops at the edge that samples `frame_end` high or `frame_active` low. The mode inputs reach `rx_active` combinationally, except for the debug hold, which is registered and follows one edge later. The bench drives every input and compares every output at the falling edge, after the model has stepped on the rising edge. Each result is therefore checked exactly in the half cycle after the edge that produced it.

// File: rtl/rx_ctrl_reg.sv
module rx_ctrl_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          frame_active,
  input  logic          frame_end,
  input  logic          word_start,
  input  logic          stop_mode,
  input  logic          lls_mode,
  input  logic          debug_mode,
  output logic          rx_active,
  output logic          bclk_on,
  output logic          fifo_rst,
  output logic          soft_rst
);
  localparam int B_EN  = 31;
  localparam int B_STE = 30;
  localparam int B_DBE = 29;
  localparam int B_BCE = 28;
  localparam int B_FRS = 25;
  localparam int B_SRS = 24;
  localparam int B_WSF = 20;

  logic en_q, en_req, bce_q, bce_req, ste_q, dbe_q, hold_q, wsf_q;
  logic keep, en_req_n, bce_req_n, en_n, hold_want;

  assign keep      = frame_active && !frame_end;
  assign en_req_n  = wr_en ? wdata[B_EN] : en_req;
  assign bce_req_n = wr_en ? (wdata[B_BCE] | wdata[B_EN]) : bce_req;
  assign en_n      = en_req_n | (en_q & keep);
  assign hold_want = debug_mode & ~dbe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_req   <= 1'b0;
      en_q     <= 1'b0;
      bce_req  <= 1'b0;
      bce_q    <= 1'b0;
      ste_q    <= 1'b0;
      dbe_q    <= 1'b0;
      hold_q   <= 1'b0;
      wsf_q    <= 1'b0;
      fifo_rst <= 1'b0;
      soft_rst <= 1'b0;
    end else begin
      en_req   <= en_req_n;
      en_q     <= en_n;
      bce_req  <= bce_req_n;
      bce_q    <= bce_req_n | en_n | (bce_q & keep);
      hold_q   <= hold_want & (hold_q | ~keep);
      fifo_rst <= wr_en & (wdata[B_FRS] | wdata[B_SRS]);
      soft_rst <= wr_en & wdata[B_SRS];
      if (wr_en) begin
        ste_q <= wdata[B_STE];
        dbe_q <= wdata[B_DBE];
      end
      if (word_start)
        wsf_q <= 1'b1;
      else if (wr_en && (wdata[B_WSF] || wdata[B_SRS]))
        wsf_q <= 1'b0;
    end
  end

  assign rx_active = en_q & ~hold_q & ~lls_mode & (~stop_mode | ste_q);
  assign bclk_on   = bce_q;

  always_comb begin
    rdata        = '0;
    rdata[B_EN]  = en_q;
    rdata[B_STE] = ste_q;
    rdata[B_DBE] = dbe_q;
    rdata[B_BCE] = bce_q;
    rdata[B_WSF] = wsf_q;
  end

  p_defer_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[B_EN] && frame_active && !frame_end) |=> rdata[B_EN]);
  p_en_forces_bclk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[B_EN] |-> bclk_on);
  p_bclk_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_on && frame_active && !frame_end) |=> bclk_on);
  p_soft_has_fifo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> fifo_rst);
  p_lls_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lls_mode |-> !rx_active);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |=> rdata[B_WSF]);
  p_pulse_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !fifo_rst);
endmodule

// File: tb/rx_ctrl_reg_test.sv
module rx_ctrl_reg_test;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wdata = 0, rdata;
  logic frame_active = 0, frame_end = 0, word_start = 0;
  logic stop_mode = 0, lls_mode = 0, debug_mode = 0;
  logic rx_active, bclk_on, fifo_rst, soft_rst;
  int checks = 0, fails = 0;

  bit m_en, m_req, m_bce, m_breq, m_se, m_de, m_blk, m_wsf, m_fr, m_sr;

  always #5 clk = ~clk;

  rx_ctrl_reg uut (.clk, .rst_n, .wr_en, .wdata, .rdata, .frame_active, .frame_end,
    .word_start, .stop_mode, .lls_mode, .debug_mode, .rx_active, .bclk_on,
    .fifo_rst, .soft_rst);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit busy, want, nen, nbce;
    busy = frame_active && !frame_end;
    want = debug_mode && !m_de;
    if (wr_en) begin
      m_req = wdata[31];
      m_breq = wdata[31] || wdata[28];
    end
    nen = m_req || (m_en && busy);
    nbce = m_breq || nen || (m_bce && busy);
    m_blk = want && (m_blk || !busy);
    if (word_start) m_wsf = 1;
    else if (wr_en && (wdata[20] || wdata[24])) m_wsf = 0;
    m_fr = wr_en && (wdata[25] || wdata[24]);
    m_sr = wr_en && wdata[24];
    if (wr_en) begin
      m_se = wdata[30];
      m_de = wdata[29];
    end
    m_en = nen;
    m_bce = nbce;
  endtask

  task automatic compare();
    bit act_exp;
    act_exp = m_en && !m_blk && !lls_mode && (!stop_mode || m_se);
    chk("R1 enable readback", rdata[31], m_en);
    chk("R2 bit clock readback", rdata[28], m_bce);
    chk("R3 bclk_on", bclk_on, m_bce);
    chk("R4 fifo_rst", fifo_rst, m_fr);
    chk("R5 soft_rst", soft_rst, m_sr);
    chk("R5 config keep", {rdata[30], rdata[29]}, {m_se, m_de});
    chk("R6/R7 rx_active", rx_active, act_exp);
    chk("R8 word flag", rdata[20], m_wsf);
    chk("R9 reserved zero", rdata & 32'h0FEF_FFFF, 0);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    wr_en = 0;
    word_start = 0;
    frame_end = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1;
    wdata = d;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset rdata", rdata, 0);
    chk("R1 reset rx_active", rx_active, 0);
    rst_n = 1;
    @(negedge clk);
    // R1/R2: enable sets bit clock; defer clear across a frame
    wr(32'h8000_0000);
    frame_active = 1;
    idle(2);
    wr(32'h0000_0000);
    idle(3);
    chk("R1 held mid frame", rdata[31], 1);
    frame_end = 1;
    tick();
    chk("R1 dropped at frame end", rdata[31], 0);
    frame_active = 0;
    idle(1);
    // R1 idle clear, re-enable cancels pending clear
    wr(32'h8000_0000);
    wr(32'h0000_0000);
    chk("R1 idle clear next cycle", rdata[31], 0);
    frame_active = 1;
    wr(32'h8000_0000);
    wr(32'h0000_0000);
    wr(32'h8000_0000);
    idle(2);
    chk("R1 re-enable cancels", rdata[31], 1);
    // R3: bit clock alone
    wr(32'h1000_0000);
    idle(2);
    wr(32'h0000_0000);
    idle(2);
    chk("R3 bclk held mid frame", bclk_on, 1);
    frame_end = 1;
    tick();
    idle(1);
    chk("R3 bclk off after frame", bclk_on, 0);
    frame_active = 0;
    // R6: stop and low-leakage modes
    wr(32'h8000_0000);
    stop_mode = 1;
    idle(2);
    wr(32'hC000_0000);
    idle(2);
    lls_mode = 1;
    idle(2);
    chk("R6 lls forces off", rx_active, 0);
    lls_mode = 0;
    stop_mode = 0;
    idle(1);
    // R7: debug with disable, mid frame
    frame_active = 1;
    debug_mode = 1;
    idle(3);
    chk("R7 runs until frame end", rx_active, 1);
    frame_end = 1;
    tick();
    idle(2);
    chk("R7 off after frame", rx_active, 0);
    chk("R7 bclk unaffected", bclk_on, 1);
    wr(32'hA000_0000);
    idle(1);
    chk("R7 debug enable restores", rx_active, 1);
    debug_mode = 0;
    frame_active = 0;
    idle(1);
    // R8: word-start flag
    word_start = 1;
    tick();
    wr(32'h8000_0000);
    chk("R8 write 0 no effect", rdata[20], 1);
    wr(32'h8010_0000);
    chk("R8 w1c clears", rdata[20], 0);
    word_start = 1;
    wr(32'h8010_0000);
    chk("R8 set wins", rdata[20], 1);
    // R4/R5: pulses and soft reset
    wr(32'h8200_0000);
    chk("R4 fifo pulse", fifo_rst, 1);
    idle(1);
    chk("R4 single cycle", fifo_rst, 0);
    wr(32'hF100_0000);
    chk("R5 soft pulse", soft_rst, 1);
    chk("R5 flag cleared", rdata[20], 0);
    chk("R5 config kept", rdata[31:28], 4'hF);
    // R9: reserved bits ignore writes
    wr(32'hFFFF_FFFF);
    idle(1);
    chk("R9 readback mask", rdata & 32'h0FEF_FFFF, 0);
    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule